// File: doc/BRIEF.md
# Wrapped Line Refill Controller

This block runs the refill of one cache line after a miss. It takes the miss (line address and the word the processor asked for), sends one request to the next memory level for the line starting at that word, and expects the memory to return the eight words as beats in wrap-around order: the requested word, then the following words, wrapping past the end of the line back to word zero. The first beat to arrive is passed straight to the processor in the same cycle, so the processor can resume. The rest of the line keeps filling in the background.

Every accepted beat is written into the cache line through a write port that carries the line address, the word position and the data. A small fill buffer keeps one valid bit per word. A later access to the line being filled is served at once if its word is already present, or if that word is arriving in the same cycle. Otherwise it waits until the word arrives. The line is reported complete one cycle after its last word has been written, and the controller is then idle and can take the next miss. Tag lookup and the choice of victim are done outside this block.

The miss input, the memory request, the memory response and the access port each use a valid/ready handshake. A transfer happens on a rising clock edge where both valid and ready are high. A source that raises valid keeps it and its payload stable until the transfer. The block applies back-pressure only through its ready outputs: miss_ready is high only when the controller is idle, mem_rsp_ready only during the fill phase, and acc_ready only when the requested word can be returned.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it: miss_ready is 1, and mem_req_valid, mem_rsp_ready, fill_we, crit_valid, acc_ready and line_done are all 0.
- R2: A miss is taken on a cycle where miss_valid and miss_ready are both high. From the next cycle, mem_req_valid is high with mem_req_line equal to the miss line and mem_req_word equal to the requested word, and it stays high and stable until mem_req_ready is seen. miss_ready stays low from the accepted miss until the controller is idle again.
- R3: mem_rsp_ready is high only after the request handshake and until the last beat. A response offered before the request has been accepted is not taken.
- R4: Beat i of a fill (i = 0 to 7, counting accepted beats only) is written in the cycle it is accepted: fill_we is 1, fill_word is (requested word + i) mod 8, fill_data is the beat data and fill_line is the miss line.
- R5: crit_valid is high for exactly one cycle per fill, in the cycle the first beat is accepted, and crit_data then equals that beat's data.
- R6: An access (acc_valid, with acc_word in 0 to 7) to a word of the filling line that has already been written gets acc_ready in the same cycle, with acc_data equal to the stored word.
- R7: An access to a word not yet written keeps acc_ready low until the beat for that word is accepted. In that cycle acc_ready is high and acc_data equals the arriving beat.
- R8: line_done is high for one cycle, the cycle after the last beat is written. In that same cycle miss_ready is high again.
- R9: Cycles in which mem_rsp_valid is low during a fill do not advance the beat count, and no write happens in them.
- R10: While idle, an access is never acknowledged.
- R11: Accepting a new miss clears all word valid bits. An access made before the new line's beat for that word arrives stalls, even if the previous fill held that word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Controller idle, miss can be taken |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | OFF_W | Word the processor needs |
| mem_req_valid | output | 1 | Refill request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | LINE_W | Line to fetch |
| mem_req_word | output | OFF_W | Word to return first |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_ready | output | 1 | Controller takes the beat |
| mem_rsp_data | input | DATA_W | Beat data |
| crit_valid | output | 1 | One-cycle pulse: requested word for the processor |
| crit_data | output | DATA_W | Requested word |
| acc_valid | input | 1 | Access to the filling line valid |
| acc_ready | output | 1 | Access served this cycle |
| acc_word | input | OFF_W | Word position of the access |
| acc_data | output | DATA_W | Data returned to the access |
| fill_we | output | 1 | Cache line write enable |
| fill_line | output | LINE_W | Line being written |
| fill_word | output | OFF_W | Word position being written |
| fill_data | output | DATA_W | Word being written |
| line_done | output | 1 | One-cycle pulse: line complete |

## Verification
The bench chooses requested words that make the wrap visible. A requested word of 5 checks that beat 3 lands at word 0. A requested word of 7 checks that the very first beat wraps, and a requested word of 0 checks that nothing wraps at all. A controller that counted from word zero, or used the beat count as the position, writes data to the wrong positions. Accesses are placed on both sides of each word's arrival: one during the request phase, one in the exact cycle of its beat, and one after it. A design missing the same-cycle bypass stalls one cycle too long, and one that does not clear the valid bits returns a word left from the previous line. Gaps in the response stream and a response offered before the request handshake catch beat counters that advance without a transfer. An early completion pulse or an early return to idle shows up as miss_ready rising before the last write.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_FILL = 2'd2
  } fill_st_e;
endpackage

// File: rtl/cwf_wrap_seq.sv
module cwf_wrap_seq #(
  parameter int WORDS = 8,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_word,
  input  logic             advance,
  output logic [OFF_W-1:0] start_word,
  output logic [OFF_W-1:0] word_idx,
  output logic             first_o,
  output logic             last_o
);
  logic [OFF_W-1:0] start_q;
  logic [OFF_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= load_word;
      beat_q  <= '0;
    end else if (advance) begin
      beat_q  <= beat_q + OFF_W'(1);
    end
  end

  // position = (start + beat) mod WORDS
  always_comb begin
    int s;
    s = int'(start_q) + int'(beat_q);
    if (s >= WORDS) s = s - WORDS;
    word_idx = OFF_W'(s);
  end

  assign start_word = start_q;
  assign first_o    = (beat_q == '0);
  assign last_o     = (beat_q == OFF_W'(WORDS - 1));

  // R4: consecutive beats land on consecutive positions, wrapping
  a_r4_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last_o && !load) |=>
      (word_idx == OFF_W'((int'($past(word_idx)) + 1) % WORDS)));
endmodule

// File: rtl/cwf_fill_buf.sv
module cwf_fill_buf #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int OFF_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_word,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_data
);
  logic [WORDS-1:0]  vbits;
  logic [DATA_W-1:0] data_q [WORDS];
  logic              byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vbits <= '0;
    else if (clear)   vbits <= '0;
    else if (wr_en)   vbits[wr_word] <= 1'b1;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_word == OFF_W'(i))) data_q[i] <= wr_data;
    end
  end

  // a word arriving this cycle is returned without waiting for storage
  assign byp     = wr_en && (wr_word == rd_word);
  assign rd_ok   = rd_en && (vbits[rd_word] || byp);
  assign rd_data = byp ? wr_data : data_q[rd_word];

  // R11: a new fill starts with no word present
  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vbits == '0));
endmodule

// File: rtl/cwf_fsm.sv
module cwf_fsm
  import cwf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     miss_fire,
  input  logic     req_ready,
  input  logic     beat_fire,
  input  logic     last_beat,
  output fill_st_e state_o,
  output logic     done_o
);
  fill_st_e st_q, st_d;
  logic     done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE: if (miss_fire) st_d = FS_REQ;
      FS_REQ:  if (req_ready) st_d = FS_FILL;
      FS_FILL: if (beat_fire && last_beat) st_d = FS_IDLE;
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == FS_FILL) && beat_fire && last_beat;
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
  import cwf_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int LINE_W = 26,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [OFF_W-1:0]  miss_word,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [OFF_W-1:0]  mem_req_word,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              crit_valid,
  output logic [DATA_W-1:0] crit_data,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [OFF_W-1:0]  acc_word,
  output logic [DATA_W-1:0] acc_data,
  output logic              fill_we,
  output logic [LINE_W-1:0] fill_line,
  output logic [OFF_W-1:0]  fill_word,
  output logic [DATA_W-1:0] fill_data,
  output logic              line_done
);
  fill_st_e          st;
  logic              miss_fire, beat_fire;
  logic              first_beat, last_beat;
  logic [OFF_W-1:0]  beat_word, start_word;
  logic [LINE_W-1:0] line_q;

  assign miss_ready    = (st == FS_IDLE);
  assign miss_fire     = miss_valid && miss_ready;
  assign mem_req_valid = (st == FS_REQ);
  assign mem_rsp_ready = (st == FS_FILL);
  assign beat_fire     = mem_rsp_valid && mem_rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         line_q <= '0;
    else if (miss_fire) line_q <= miss_line;
  end

  cwf_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_fire (miss_fire),
    .req_ready (mem_req_ready),
    .beat_fire (beat_fire),
    .last_beat (last_beat),
    .state_o   (st),
    .done_o    (line_done)
  );

  cwf_wrap_seq #(.WORDS(WORDS), .OFF_W(OFF_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (miss_fire),
    .load_word  (miss_word),
    .advance    (beat_fire),
    .start_word (start_word),
    .word_idx   (beat_word),
    .first_o    (first_beat),
    .last_o     (last_beat)
  );

  cwf_fill_buf #(.WORDS(WORDS), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (miss_fire),
    .wr_en   (beat_fire),
    .wr_word (beat_word),
    .wr_data (mem_rsp_data),
    .rd_en   (acc_valid && (st != FS_IDLE)),
    .rd_word (acc_word),
    .rd_ok   (acc_ready),
    .rd_data (acc_data)
  );

  assign mem_req_line = line_q;
  assign mem_req_word = start_word;
  assign fill_we      = beat_fire;
  assign fill_line    = line_q;
  assign fill_word    = beat_word;
  assign fill_data    = mem_rsp_data;
  assign crit_valid   = beat_fire && first_beat;
  assign crit_data    = mem_rsp_data;

  // R2: a pending request holds its payload
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_word) && $stable(mem_req_line)));
  // R5: the forwarded word is the requested one
  a_r5_crit_position: assert property (@(posedge clk) disable iff (!rst_n)
    crit_valid |-> (fill_word == mem_req_word));
  // R8: completion follows a write
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> ($past(fill_we) && miss_ready));
  // R10: no access served while idle
  a_r10_idle_no_acc: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !miss_ready);
endmodule

// File: tb/tb_cwf_fill_ctrl.sv
`timescale 1ns/1ps
module tb_cwf_fill_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        miss_valid = 0, miss_ready;
  logic [25:0] miss_line = '0;
  logic [2:0]  miss_word = '0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [25:0] mem_req_line;
  logic [2:0]  mem_req_word;
  logic        mem_rsp_valid = 0, mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        crit_valid;
  logic [31:0] crit_data;
  logic        acc_valid = 0, acc_ready;
  logic [2:0]  acc_word = '0;
  logic [31:0] acc_data;
  logic        fill_we;
  logic [25:0] fill_line;
  logic [2:0]  fill_word;
  logic [31:0] fill_data;
  logic        line_done;

  int vecs = 0, fails = 0;

  always #2.5 clk = ~clk;

  cwf_fill_ctrl dut (.*);

  function automatic logic [31:0] mdata(input int line, input int w);
    return 32'(line * 37 + w * 4097) ^ 32'h5A00_0000;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated each falling edge
  bit   mdl_on = 0;
  int   m_ph = 0;          // 0 idle, 1 request, 2 fill
  int   m_line = 0, m_start = 0, m_beat = 0;
  bit   m_done = 0;
  bit   mv [8];
  logic [31:0] md [8];

  always @(negedge clk) begin
    bit hs, eok, byp;
    int idx;
    if (mdl_on) begin
      hs  = (m_ph == 2) && mem_rsp_valid;
      idx = (m_start + m_beat) % 8;
      byp = hs && (idx == int'(acc_word));
      eok = (m_ph != 0) && acc_valid && (mv[acc_word] || byp);
      chk("R2 miss_ready", miss_ready, m_ph == 0);
      chk("R2 mem_req_valid", mem_req_valid, m_ph == 1);
      if (m_ph == 1) begin
        chk("R2 mem_req_word", mem_req_word, m_start);
        chk("R2 mem_req_line", mem_req_line, m_line);
      end
      chk("R3 mem_rsp_ready", mem_rsp_ready, m_ph == 2);
      chk("R4 R9 fill_we", fill_we, hs);
      if (hs) begin
        chk("R4 fill_word", fill_word, idx);
        chk("R4 fill_data", fill_data, mdata(m_line, idx));
        chk("R4 fill_line", fill_line, m_line);
      end
      chk("R5 crit_valid", crit_valid, hs && m_beat == 0);
      if (hs && m_beat == 0) chk("R5 crit_data", crit_data, mdata(m_line, m_start));
      chk("R6 R7 R10 R11 acc_ready", acc_ready, eok);
      if (eok) chk("R6 R7 acc_data", acc_data, byp ? mdata(m_line, idx) : md[acc_word]);
      chk("R8 line_done", line_done, m_done);
      // advance model to the state after the coming edge
      m_done = 0;
      case (m_ph)
        0: if (miss_valid) begin
             m_ph = 1; m_line = int'(miss_line); m_start = int'(miss_word);
             for (int k = 0; k < 8; k++) mv[k] = 0;
           end
        1: if (mem_req_ready) begin m_ph = 2; m_beat = 0; end
        default: if (hs) begin
             mv[idx] = 1; md[idx] = mdata(m_line, idx);
             if (m_beat == 7) begin m_ph = 0; m_done = 1; end
             else m_beat++;
           end
      endcase
    end
  end

  task automatic do_miss(input int line, input int w);
    miss_valid = 1; miss_line = 26'(line); miss_word = 3'(w);
    @(posedge clk); #1;
    miss_valid = 0;
  endtask

  task automatic do_mem(input int line, input int off, input int reqd,
                        input bit gap, input bit early);
    do @(negedge clk); while (!mem_req_valid);
    repeat (reqd) begin @(posedge clk); #1; end
    mem_req_ready = 1;
    if (early) begin mem_rsp_valid = 1; mem_rsp_data = mdata(line, off); end
    @(posedge clk); #1;
    mem_req_ready = 0;
    for (int i = 0; i < 8; i++) begin
      if (gap && (i % 2 == 1)) begin
        mem_rsp_valid = 0;
        repeat (2) begin @(posedge clk); #1; end
      end
      mem_rsp_valid = 1; mem_rsp_data = mdata(line, (off + i) % 8);
      do @(negedge clk); while (!mem_rsp_ready);
      @(posedge clk); #1;
    end
    mem_rsp_valid = 0;
  endtask

  task automatic do_acc(input int w, input int dly, input int tmo);
    int n;
    repeat (dly) begin @(posedge clk); #1; end
    acc_valid = 1; acc_word = 3'(w);
    n = 0;
    do begin @(negedge clk); n++; end while (!acc_ready && n < tmo);
    @(posedge clk); #1;
    acc_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1 miss_ready", miss_ready, 1);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 mem_rsp_ready", mem_rsp_ready, 0);
    chk("R1 fill_we", fill_we, 0);
    chk("R1 crit_valid", crit_valid, 0);
    chk("R1 acc_ready", acc_ready, 0);
    chk("R1 line_done", line_done, 0);
    @(posedge clk); #1;
    rst_n = 1; mdl_on = 1;
    @(posedge clk); #1;
    // wrap from word 5, access to word 2 stalls (R7)
    fork
      do_miss(100, 5);
      do_mem(100, 5, 2, 0, 0);
      begin do_acc(2, 3, 60); do_acc(5, 0, 60); end
    join
    repeat (2) begin @(posedge clk); #1; end
    // no wrap, gaps in the stream (R9), early offer (R3), present word (R6)
    fork
      do_miss(2001, 0);
      do_mem(2001, 0, 1, 1, 1);
      begin do_acc(0, 8, 60); do_acc(7, 0, 60); end
    join
    repeat (2) begin @(posedge clk); #1; end
    // first beat wraps, access during request phase meets the bypass
    fork
      do_miss(777, 7);
      do_mem(777, 7, 3, 0, 0);
      do_acc(7, 1, 60);
    join
    repeat (2) begin @(posedge clk); #1; end
    // idle access is ignored (R10)
    do_acc(3, 1, 6);
    // old contents must not serve the new line (R11)
    fork
      do_miss(4242, 3);
      do_mem(4242, 3, 2, 0, 0);
      begin do_acc(3, 1, 60); do_acc(1, 0, 60); end
    join
    repeat (3) begin @(posedge clk); #1; end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule